// File: doc/BRIEF.md
# PLL coefficient search engine

This block picks the three divider settings of a fractional-free PLL for a requested output frequency. The PLL output is the VCO frequency divided by a post divider and then halved, and the VCO frequency is the reference frequency multiplied by N and divided by M. All values are whole MHz. A request is a one-cycle `start` with the requested frequency and the reference frequency on the inputs. The engine then walks through the allowed post-divider indices, M values and N candidates over many clock cycles. It uses one shared sequential divider for every quotient.

The engine keeps the candidate with the smallest output error. It stops early when the error is zero. When it finishes it pulses `done` and presents M, N, the post-divider index and two flags: an exact-match flag and a no-candidate flag. The post divider is selected by a 4-bit index into a fixed table whose ratios are not monotonic. The PL range is bounded from the VCO window, and the M range is bounded from the window on the intermediate frequency ref/M.

Top module: `pll_coef_search`

## Requirements
- R1: A `start` seen while idle raises `busy` on the next clock and captures `target_mhz` and `ref_mhz`. A `start` seen while `busy` is high is ignored, and the result is that of the request already running.
- R2: Post-divider index i selects ratio 1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32 for i = 0 to 14. `pl_idx` reports that index.
- R3: The internal target is T = 2 x `target_mhz`. The VCO target is V = T + floor(T/50), and the VCO ceiling Vmax is the larger of 2064 and V. The PL range is computed in three steps:
  - the upper ratio bound is ceil(Vmax/V) and the lower ratio bound is floor(1000/V), each clamped to 1..32;
  - each bound becomes the first index in 0..13 whose ratio is at least the bound, or 14 if there is none;
  - the index range is searched in increasing order.
- R4: For each index, M rises from 1. The M loop for that index stops when floor(ref/M) < 12 or when M passes 255. An M value with floor(ref/M) > 38 is skipped.
- R5: Let Q = T x ratio x M / ref. The N candidates run from floor(Q) to ceil(Q). The M loop stops when floor(Q) > 255. A candidate N below 8 is skipped, and a candidate N above 255 ends the N loop.
- R6: A candidate is valid only if floor(ref x N / M) lies in [1000, Vmax].
- R7: The error of a valid candidate is |floor((vco + floor(ratio/2)) / ratio) - T|. The result is replaced only by a strictly smaller error, so the first candidate found wins a tie.
- R8: A zero-error candidate ends the search at once and sets `exact`.
- R9: If no candidate is valid, the result is M = 255, N = 8, PL index = 1, with `none_found` = 1 and `exact` = 0.
- R10: `done` is high for exactly one cycle, and `busy` is low in that cycle. The result outputs change only on that edge and hold their values until the next `done`.
- R11: After reset, `busy`, `done`, `exact`, `none_found`, `m_coef`, `n_coef` and `pl_idx` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only while idle |
| target_mhz | input | FW | Requested output frequency in MHz |
| ref_mhz | input | FW | Reference frequency in MHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| m_coef | output | clog2(MAX_M+1) | Chosen reference divider M |
| n_coef | output | clog2(MAX_N+1) | Chosen feedback multiplier N |
| pl_idx | output | 4 | Chosen post-divider index |
| exact | output | 1 | Result has zero output error |
| none_found | output | 1 | No valid candidate existed; defaults reported |

## Verification
The assertions check on every cycle the handshake and the shape of the result:
- acceptance of `start` while idle, and the single-cycle `done` with `busy` already low;
- outputs held between completions;
- the default triple whenever no candidate existed;
- the legal ranges of M, N and the index on any result that was found.

Only the bench scenarios can show that the search itself picks the right triple. That covers the PL bound mapping, the M and N stopping rules, the raised VCO ceiling for high targets, tie-breaking by first find, the early exit, and the ignoring of a `start` that arrives mid-search. The bench shows these by comparing against an arithmetic model over a sweep of target and reference pairs.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

  localparam int PLW          = 4;
  localparam int RBW          = 6;
  localparam int PL_RMIN      = 1;
  localparam int PL_RMAX      = 32;
  localparam int PL_LAST      = 14;
  localparam int PL_SCAN_LAST = 13;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIV50,
    ST_HIGH,
    ST_LOW,
    ST_PLSET,
    ST_UF,
    ST_NDIV,
    ST_NCHK,
    ST_VCO,
    ST_ERR,
    ST_NEXTPL,
    ST_DONE
  } srch_state_t;

  // post-divider ratio for a table index (not monotonic past index 9)
  function automatic logic [RBW-1:0] pl_ratio(input logic [PLW-1:0] idx);
    logic [RBW-1:0] r;
    case (idx)
      4'd0:    r = 6'd1;
      4'd1:    r = 6'd2;
      4'd2:    r = 6'd3;
      4'd3:    r = 6'd4;
      4'd4:    r = 6'd5;
      4'd5:    r = 6'd6;
      4'd6:    r = 6'd8;
      4'd7:    r = 6'd10;
      4'd8:    r = 6'd12;
      4'd9:    r = 6'd16;
      4'd10:   r = 6'd12;
      4'd11:   r = 6'd16;
      4'd12:   r = 6'd20;
      4'd13:   r = 6'd24;
      default: r = 6'd32;
    endcase
    return r;
  endfunction

  // first index in 0..13 whose ratio reaches the bound, else the last index
  function automatic logic [PLW-1:0] pl_index_for(input logic [RBW-1:0] bound);
    logic [PLW-1:0] r;
    r = PLW'(PL_LAST);
    for (int i = PL_SCAN_LAST; i >= 0; i--) begin
      if (pl_ratio(PLW'(i)) >= bound) r = PLW'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/pllsrch_divider.sv
module pllsrch_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dsr_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    shifted, diff;
  logic          ge;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = shifted - {1'b0, dsr_q};
    ge      = (shifted >= {1'b0, dsr_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !run_q) begin
        rem_q <= '0;
        quo_q <= dividend;
        dsr_q <= divisor;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? diff[W-1:0] : shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;
endmodule

// File: rtl/pllsrch_best.sv
module pllsrch_best #(
  parameter int MOW    = 8,
  parameter int NOW    = 8,
  parameter int EW     = 32,
  parameter int DEF_M  = 255,
  parameter int DEF_N  = 8,
  parameter int DEF_PL = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           offer,
  input  logic [MOW-1:0] cand_m,
  input  logic [NOW-1:0] cand_n,
  input  logic [3:0]     cand_pl,
  input  logic [EW-1:0]  cand_err,
  output logic [MOW-1:0] best_m,
  output logic [NOW-1:0] best_n,
  output logic [3:0]     best_pl,
  output logic [EW-1:0]  best_err,
  output logic           found
);
  logic better;
  assign better = offer && (cand_err < best_err);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      best_m   <= MOW'(DEF_M);
      best_n   <= NOW'(DEF_N);
      best_pl  <= 4'(DEF_PL);
      best_err <= '1;
      found    <= 1'b0;
    end else if (better) begin
      best_m   <= cand_m;
      best_n   <= cand_n;
      best_pl  <= cand_pl;
      best_err <= cand_err;
      found    <= 1'b1;
    end
  end
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
  import pllsrch_pkg::*;
#(
  parameter int FW         = 12,
  parameter int DW         = 32,
  parameter int MIN_VCO    = 1000,
  parameter int MAX_VCO    = 2064,
  parameter int MIN_UF     = 12,
  parameter int MAX_UF     = 38,
  parameter int MIN_M      = 1,
  parameter int MAX_M      = 255,
  parameter int MIN_N      = 8,
  parameter int MAX_N      = 255,
  parameter int MARGIN_DIV = 50,
  parameter int DEF_PL     = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [FW-1:0]              target_mhz,
  input  logic [FW-1:0]              ref_mhz,
  output logic                       busy,
  output logic                       done,
  output logic [$clog2(MAX_M+1)-1:0] m_coef,
  output logic [$clog2(MAX_N+1)-1:0] n_coef,
  output logic [3:0]                 pl_idx,
  output logic                       exact,
  output logic                       none_found
);
  localparam int MOW = $clog2(MAX_M + 1);
  localparam int NOW = $clog2(MAX_N + 1);
  localparam int MW  = MOW + 1;
  localparam int NW  = NOW + 1;
  localparam int TW  = FW + 1;

  srch_state_t    st;
  logic           issued;
  logic [TW-1:0]  t2_q;
  logic [FW-1:0]  ref_q;
  logic [DW-1:0]  tvco_q, vmax_q, tv_q, vco_q;
  logic [PLW-1:0] hi_q, pl_q;
  logic [MW-1:0]  m_q;
  logic [NW-1:0]  n_q, n2_q;

  logic           div_start, div_done;
  logic [DW-1:0]  dvd, dvs, dq, dr;
  logic [DW-1:0]  tvco_nx, err_c;
  logic [RBW-1:0] ratio;
  logic [MW-1:0]  m_inc;
  logic           m_over;

  logic [MOW-1:0] best_m;
  logic [NOW-1:0] best_n;
  logic [3:0]     best_pl;
  logic [DW-1:0]  best_err;
  logic           found, offer, clear;

  function automatic logic [RBW-1:0] clamp_ratio(input logic [DW-1:0] q);
    if (q < DW'(PL_RMIN)) return RBW'(PL_RMIN);
    if (q > DW'(PL_RMAX)) return RBW'(PL_RMAX);
    return q[RBW-1:0];
  endfunction

  assign ratio   = pl_ratio(pl_q);
  assign m_inc   = m_q + 1'b1;
  assign m_over  = (m_inc > MW'(MAX_M));
  assign tvco_nx = DW'(t2_q) + dq;
  assign err_c   = (dq >= DW'(t2_q)) ? (dq - DW'(t2_q)) : (DW'(t2_q) - dq);

  // operand selection for the shared divider
  always_comb begin
    dvd = '0;
    dvs = DW'(1);
    case (st)
      ST_DIV50: begin dvd = DW'(t2_q);                  dvs = DW'(MARGIN_DIV); end
      ST_HIGH:  begin dvd = vmax_q + tvco_q - DW'(1);   dvs = tvco_q;          end
      ST_LOW:   begin dvd = DW'(MIN_VCO);               dvs = tvco_q;          end
      ST_UF:    begin dvd = DW'(ref_q);                 dvs = DW'(m_q);        end
      ST_NDIV:  begin dvd = tv_q * DW'(m_q);            dvs = DW'(ref_q);      end
      ST_VCO:   begin dvd = DW'(ref_q) * DW'(n_q);      dvs = DW'(m_q);        end
      ST_ERR:   begin dvd = vco_q + DW'(ratio >> 1);    dvs = DW'(ratio);      end
      default:  begin dvd = '0;                         dvs = DW'(1);          end
    endcase
  end

  assign div_start = !issued && (st == ST_DIV50 || st == ST_HIGH || st == ST_LOW ||
                                 st == ST_UF || st == ST_NDIV || st == ST_VCO ||
                                 st == ST_ERR);
  assign offer = (st == ST_ERR) && div_done;
  assign clear = (st == ST_IDLE) && start;

  pllsrch_divider #(.W(DW)) u_div (
    .clk       (clk),
    .rst       (rst),
    .start     (div_start),
    .dividend  (dvd),
    .divisor   (dvs),
    .done      (div_done),
    .quotient  (dq),
    .remainder (dr)
  );

  pllsrch_best #(
    .MOW(MOW), .NOW(NOW), .EW(DW),
    .DEF_M(MAX_M), .DEF_N(MIN_N), .DEF_PL(DEF_PL)
  ) u_best (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .offer    (offer),
    .cand_m   (m_q[MOW-1:0]),
    .cand_n   (n_q[NOW-1:0]),
    .cand_pl  (pl_q),
    .cand_err (err_c),
    .best_m   (best_m),
    .best_n   (best_n),
    .best_pl  (best_pl),
    .best_err (best_err),
    .found    (found)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      issued     <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      t2_q       <= '0;
      ref_q      <= '0;
      tvco_q     <= '0;
      vmax_q     <= '0;
      tv_q       <= '0;
      vco_q      <= '0;
      hi_q       <= '0;
      pl_q       <= '0;
      m_q        <= '0;
      n_q        <= '0;
      n2_q       <= '0;
      m_coef     <= '0;
      n_coef     <= '0;
      pl_idx     <= '0;
      exact      <= 1'b0;
      none_found <= 1'b0;
    end else begin
      done <= 1'b0;
      if (div_start) issued <= 1'b1;
      if (div_done)  issued <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          t2_q  <= {target_mhz, 1'b0};
          ref_q <= ref_mhz;
          busy  <= 1'b1;
          st    <= ST_DIV50;
        end
        ST_DIV50: if (div_done) begin
          tvco_q <= tvco_nx;
          vmax_q <= (tvco_nx > DW'(MAX_VCO)) ? tvco_nx : DW'(MAX_VCO);
          st     <= ST_HIGH;
        end
        ST_HIGH: if (div_done) begin
          hi_q <= pl_index_for(clamp_ratio(dq));
          st   <= ST_LOW;
        end
        ST_LOW: if (div_done) begin
          pl_q <= pl_index_for(clamp_ratio(dq));
          st   <= ST_PLSET;
        end
        ST_PLSET: begin
          if (pl_q > hi_q) st <= ST_DONE;
          else begin
            tv_q <= DW'(t2_q) * DW'(ratio);
            m_q  <= MW'(MIN_M);
            st   <= ST_UF;
          end
        end
        ST_UF: if (div_done) begin
          if (dq < DW'(MIN_UF)) st <= ST_NEXTPL;
          else if (dq > DW'(MAX_UF)) begin
            m_q <= m_inc;
            st  <= m_over ? ST_NEXTPL : ST_UF;
          end else st <= ST_NDIV;
        end
        ST_NDIV: if (div_done) begin
          if (dq > DW'(MAX_N)) st <= ST_NEXTPL;
          else begin
            n_q  <= dq[NW-1:0];
            n2_q <= dq[NW-1:0] + NW'(dr != '0);
            st   <= ST_NCHK;
          end
        end
        ST_NCHK: begin
          if (n_q > n2_q || n_q > NW'(MAX_N)) begin
            m_q <= m_inc;
            st  <= m_over ? ST_NEXTPL : ST_UF;
          end else if (n_q < NW'(MIN_N)) n_q <= n_q + 1'b1;
          else st <= ST_VCO;
        end
        ST_VCO: if (div_done) begin
          if (dq >= DW'(MIN_VCO) && dq <= vmax_q) begin
            vco_q <= dq;
            st    <= ST_ERR;
          end else begin
            n_q <= n_q + 1'b1;
            st  <= ST_NCHK;
          end
        end
        ST_ERR: if (div_done) begin
          if (err_c == '0) st <= ST_DONE;
          else begin
            n_q <= n_q + 1'b1;
            st  <= ST_NCHK;
          end
        end
        ST_NEXTPL: begin
          if (pl_q >= hi_q) st <= ST_DONE;
          else begin
            pl_q <= pl_q + 1'b1;
            st   <= ST_PLSET;
          end
        end
        ST_DONE: begin
          m_coef     <= best_m;
          n_coef     <= best_n;
          pl_idx     <= best_pl;
          exact      <= found && (best_err == '0);
          none_found <= !found;
          done       <= 1'b1;
          busy       <= 1'b0;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_coef_search_chk.sv
module pll_coef_search_chk #(
  parameter int MOW   = 8,
  parameter int NOW   = 8,
  parameter int MAX_M = 255,
  parameter int MIN_N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [MOW-1:0] m_coef,
  input logic [NOW-1:0] n_coef,
  input logic [3:0]     pl_idx,
  input logic           exact,
  input logic           none_found
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R1
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !done) |-> ($stable(m_coef) && $stable(n_coef) && $stable(pl_idx)
                            && $stable(exact) && $stable(none_found)));

  // R9
  default_result_chk: assert property (@(posedge clk) disable iff (rst)
    (done && none_found) |-> (m_coef == MOW'(MAX_M) && n_coef == NOW'(MIN_N)
                              && pl_idx == 4'd1 && !exact));

  // R5
  legal_range_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !none_found) |-> (n_coef >= NOW'(MIN_N) && m_coef != '0 && pl_idx <= 4'd14));
endmodule

bind pll_coef_search pll_coef_search_chk #(
  .MOW($clog2(MAX_M+1)), .NOW($clog2(MAX_N+1)), .MAX_M(MAX_M), .MIN_N(MIN_N)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .m_coef(m_coef), .n_coef(n_coef), .pl_idx(pl_idx),
  .exact(exact), .none_found(none_found)
);

// File: tb/pll_coef_search_tb.sv
`timescale 1ns/1ps
module pll_coef_search_tb;
  localparam int FW = 12;
  localparam int WD = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [FW-1:0] target_mhz = '0;
  logic [FW-1:0] ref_mhz = '0;
  logic          busy, done, exact, none_found;
  logic [7:0]    m_coef, n_coef;
  logic [3:0]    pl_idx;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pll_coef_search #(.FW(FW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .target_mhz(target_mhz), .ref_mhz(ref_mhz),
    .busy(busy), .done(done), .m_coef(m_coef), .n_coef(n_coef), .pl_idx(pl_idx),
    .exact(exact), .none_found(none_found)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R2 ratio table
  function automatic int ratio_of(input int i);
    case (i)
      0: return 1;   1: return 2;   2: return 3;   3: return 4;   4: return 5;
      5: return 6;   6: return 8;   7: return 10;  8: return 12;  9: return 16;
      10: return 12; 11: return 16; 12: return 20; 13: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic int to_index(input int b);
    int c;
    c = (b < 1) ? 1 : ((b > 32) ? 32 : b);
    for (int i = 0; i <= 13; i++) if (ratio_of(i) >= c) return i;
    return 14;
  endfunction

  // arithmetic model of R3..R9
  task automatic model(input int tgt, input int rf,
                       output int om, output int on, output int opl,
                       output int oex, output int onf);
    int t, v, vmax, hi, lo, bd, fnd, stop, tv, u, n, n2, r, vco, lwv, d;
    t = 2 * tgt;
    v = t + t / 50;
    vmax = (v > 2064) ? v : 2064;
    hi = to_index((vmax + v - 1) / v);
    lo = to_index(1000 / v);
    om = 255; on = 8; opl = 1; bd = 0; fnd = 0; stop = 0;
    for (int pl = lo; pl <= hi && !stop; pl++) begin
      r = ratio_of(pl);
      tv = t * r;
      for (int m = 1; m <= 255 && !stop; m++) begin
        u = rf / m;
        if (u < 12) break;
        if (u > 38) continue;
        n = tv * m / rf;
        n2 = (tv * m + rf - 1) / rf;
        if (n > 255) break;
        for (; n <= n2 && !stop; n++) begin
          if (n < 8) continue;
          if (n > 255) break;
          vco = rf * n / m;
          if (vco >= 1000 && vco <= vmax) begin
            lwv = (vco + r / 2) / r;
            d = (lwv > t) ? lwv - t : t - lwv;
            if (!fnd || d < bd) begin
              fnd = 1; bd = d; om = m; on = n; opl = pl;
              if (d == 0) stop = 1;
            end
          end
        end
      end
    end
    oex = (fnd && bd == 0) ? 1 : 0;
    onf = fnd ? 0 : 1;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < WD) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic check_result(input string tag, input int tgt, input int rf);
    int em, en, ep, ex, enf;
    model(tgt, rf, em, en, ep, ex, enf);
    if (!done) begin
      chk("watchdog: done never seen", 0, 1);
      return;
    end
    chk("R10 busy low with done", int'(busy), 0);
    chk({tag, " M (R4)"}, int'(m_coef), em);
    chk({tag, " N (R5 R6)"}, int'(n_coef), en);
    chk({tag, " PL (R2 R3 R7)"}, int'(pl_idx), ep);
    chk({tag, " exact (R8)"}, int'(exact), ex);
    chk({tag, " none_found (R9)"}, int'(none_found), enf);
    @(negedge clk);
    chk("R10 done single cycle", int'(done), 0);
  endtask

  task automatic run(input string tag, input int tgt, input int rf);
    target_mhz = FW'(tgt);
    ref_mhz = FW'(rf);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after start", int'(busy), 1);
    wait_done();
    check_result(tag, tgt, rf);
  endtask

  initial begin
    int ps [15] = '{72, 108, 180, 252, 324, 396, 468, 540, 612, 648, 684, 708, 756, 804, 852};
    int hm, hn, hp;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11
    chk("R11 busy reset", int'(busy), 0);
    chk("R11 done reset", int'(done), 0);
    chk("R11 m reset", int'(m_coef), 0);
    chk("R11 flags reset", int'(exact) + int'(none_found), 0);

    // R3 R4 R5 R7: sweep of operating points
    foreach (ps[i]) run("sweep ref26", ps[i], 26);
    run("ref12", 100, 12);
    run("ref38", 333, 38);
    run("ref50", 500, 50);
    run("ref19", 250, 19);
    // R6: raised VCO ceiling
    run("R6 high target", 1100, 26);
    run("low target", 31, 26);
    // R9: no candidate
    run("R9 tiny target", 5, 26);
    run("R9 low ref", 200, 10);

    // R1: start during a search is ignored
    target_mhz = FW'(396);
    ref_mhz = FW'(26);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    target_mhz = FW'(804);
    ref_mhz = FW'(38);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 still busy", int'(busy), 1);
    wait_done();
    check_result("R1 ignored start", 396, 26);

    // R10: result held after done
    hm = int'(m_coef); hn = int'(n_coef); hp = int'(pl_idx);
    target_mhz = FW'(540);
    repeat (20) @(negedge clk);
    chk("R10 M held", int'(m_coef), hm);
    chk("R10 N held", int'(n_coef), hn);
    chk("R10 PL held", int'(pl_idx), hp);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule